// File: doc/BRIEF.md
# Transparent BiSync Frame Transmitter

This block turns packets into transparent BiSync frames on a byte-wide line. Packets arrive as a byte stream on a ready/valid input, and a marker flags the final byte of each packet. The line side paces the block with a one-cycle byte request strobe. For each strobe the block registers exactly one byte onto its output. That byte may be a fill character, a framing byte, a payload byte or a CRC byte.

A frame opens with SYN characters and a DLE STX start pair. The payload follows, and any byte that equals DLE is sent twice. A DLE ETX end pair and a CRC-16 trailer close the frame, with the low byte of the CRC first. If the source runs dry in the middle of a payload, the block sends a DLE SYN pad pair, which a receiver discards. Between frames the line carries all-ones fill. If another packet is already waiting when a frame ends, its SYNs go out on the very next strobe. A one-cycle done pulse marks the end of each frame and carries the CRC that was sent.

Top module: `bsc_frame_tx`

## Requirements
- R1: While reset is held and right after it, `tx_byte` is 0xFF, `done` is low and `in_ready` is low.
- R2: A strobe that arrives with no frame in progress and no valid input loads the fill byte 0xFF.
- R3: `tx_byte` changes only at a clock edge where `byte_req` is high, and each strobe loads exactly one byte.
- R4: A frame begins with exactly NUM_SYN (default 2) SYN bytes of 0x16, followed by DLE (0x10) and then STX (0x02).
- R5: Payload bytes go out in arrival order. An accepted byte is the byte loaded at that same edge. A payload byte of 0x10 is followed at once by a second 0x10, and no input is accepted on the strobe that sends that second copy.
- R6: After the last payload byte (and its second copy, if it is a DLE) the block sends DLE (0x10), ETX (0x03), the CRC low byte and then the CRC high byte.
- R7: The CRC is CRC-16 with reflected polynomial 0xA001. It is cleared to zero at the start of every frame and covers each payload byte once, including only one copy of each doubled DLE, followed by ETX. SYN, STX, pad pairs and framing DLEs do not enter it.
- R8: If `in_valid` is low at a strobe during the payload, the block sends DLE then SYN (0x10, 0x16). The pair does not enter the CRC, and the payload resumes on the following strobe.
- R9: `in_ready` is high only in a cycle with `byte_req` high in which a payload byte can be sent. No byte is consumed by framing, padding or CRC strobes.
- R10: `done` pulses for one cycle at the edge that loads the CRC high byte, and `done_crc` then equals the 16-bit CRC of that frame.
- R11: If a packet is valid when the CRC high byte has been sent, the next strobe loads that frame's first SYN, with no fill between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is present |
| in_last | input | 1 | Byte is the last one of its packet |
| in_ready | output | 1 | Byte is taken at this edge |
| byte_req | input | 1 | Line strobe: load one byte now |
| tx_byte | output | 8 | Registered line byte |
| done | output | 1 | Frame completed (one cycle) |
| done_crc | output | 16 | CRC sent in the completed frame |

## Verification
The assertions check the cycle-level rules on every cycle. The output must hold still between strobes, and an accepted byte must be the next byte loaded. Input must be refused on the strobe after a DLE is taken, and the done pulse must last a single cycle. Only the bench scenarios can show the full byte order of a frame, the CRC value and its byte order, the placement of pad pairs during an input gap, and the seamless start of a queued packet. For these, the bench compares whole captured line streams against frames it builds independently.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam logic [7:0] SYN_B  = 8'h16;
  localparam logic [7:0] DLE_B  = 8'h10;
  localparam logic [7:0] STX_B  = 8'h02;
  localparam logic [7:0] ETX_B  = 8'h03;
  localparam logic [7:0] FILL_B = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SYN, ST_HDLE, ST_STX, ST_DATA, ST_DLE2,
    ST_PAD, ST_EDLE, ST_ETX, ST_CRCL, ST_CRCH
  } tx_state_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c,
                                           input logic [7:0] b,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/bsc_crc16.sv
module bsc_crc16 #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'hA001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc_q
);
  import bsc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (en)    crc_q <= crc_step(crc_q, din, POLY);
  end

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !en) |=> (crc_q == '0));
endmodule

// File: rtl/bsc_frame_seq.sv
module bsc_frame_seq #(
  parameter int NUM_SYN = 2,
  parameter int CRC_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_req,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic [7:0]       tx_byte,
  output logic             crc_clr,
  output logic             crc_en,
  output logic [7:0]       crc_din,
  input  logic [CRC_W-1:0] crc_q,
  output logic             done,
  output logic [CRC_W-1:0] done_crc
);
  import bsc_pkg::*;

  localparam int CNT_W = $clog2(NUM_SYN + 1);
  localparam logic [CNT_W-1:0] SYN_LAST = CNT_W'(NUM_SYN - 1);

  tx_state_t        state_q, state_d;
  logic [CNT_W-1:0] syn_cnt_q, syn_cnt_d;
  logic             pend_last_q, pend_last_d;
  logic [7:0]       byte_d;
  logic             done_d;

  always_comb begin
    state_d     = state_q;
    syn_cnt_d   = syn_cnt_q;
    pend_last_d = pend_last_q;
    byte_d      = tx_byte;
    crc_clr     = 1'b0;
    crc_en      = 1'b0;
    crc_din     = ETX_B;
    in_ready    = 1'b0;
    done_d      = 1'b0;
    if (byte_req) begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            byte_d    = SYN_B;
            crc_clr   = 1'b1;
            syn_cnt_d = CNT_W'(1);
            state_d   = (NUM_SYN > 1) ? ST_SYN : ST_HDLE;
          end else begin
            byte_d = FILL_B;
          end
        end
        ST_SYN: begin
          byte_d    = SYN_B;
          syn_cnt_d = syn_cnt_q + CNT_W'(1);
          if (syn_cnt_q == SYN_LAST) state_d = ST_HDLE;
        end
        ST_HDLE: begin byte_d = DLE_B; state_d = ST_STX;  end
        ST_STX:  begin byte_d = STX_B; state_d = ST_DATA; end
        ST_DATA: begin
          if (in_valid) begin
            in_ready = 1'b1;
            byte_d   = in_data;
            crc_en   = 1'b1;
            crc_din  = in_data;
            if (in_data == DLE_B) begin
              pend_last_d = in_last;
              state_d     = ST_DLE2;
            end else if (in_last) begin
              state_d = ST_EDLE;
            end
          end else begin
            byte_d  = DLE_B;
            state_d = ST_PAD;
          end
        end
        ST_DLE2: begin
          byte_d  = DLE_B;
          state_d = pend_last_q ? ST_EDLE : ST_DATA;
        end
        ST_PAD:  begin byte_d = SYN_B; state_d = ST_DATA; end
        ST_EDLE: begin byte_d = DLE_B; state_d = ST_ETX;  end
        ST_ETX: begin
          byte_d  = ETX_B;
          crc_en  = 1'b1;
          crc_din = ETX_B;
          state_d = ST_CRCL;
        end
        ST_CRCL: begin byte_d = crc_q[7:0]; state_d = ST_CRCH; end
        ST_CRCH: begin
          byte_d  = crc_q[15:8];
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      syn_cnt_q   <= '0;
      pend_last_q <= 1'b0;
      tx_byte     <= FILL_B;
      done        <= 1'b0;
      done_crc    <= '0;
    end else begin
      state_q     <= state_d;
      syn_cnt_q   <= syn_cnt_d;
      pend_last_q <= pend_last_d;
      tx_byte     <= byte_d;
      done        <= done_d;
      if (done_d) done_crc <= crc_q;
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_req |=> $stable(tx_byte));
  // R5
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (tx_byte == $past(in_data)));
  // R5
  dle_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_data == DLE_B) |=> !in_ready);
  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  req_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (byte_req && state_q == ST_DATA));
endmodule

// File: rtl/bsc_frame_tx.sv
module bsc_frame_tx #(
  parameter int          NUM_SYN = 2,
  parameter logic [15:0] POLY    = 16'hA001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_last,
  output logic        in_ready,
  input  logic        byte_req,
  output logic [7:0]  tx_byte,
  output logic        done,
  output logic [15:0] done_crc
);
  localparam int CRC_W = 16;

  logic             crc_clr, crc_en;
  logic [7:0]       crc_din;
  logic [CRC_W-1:0] crc_q;

  bsc_crc16 #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en),
    .din(crc_din), .crc_q(crc_q)
  );

  bsc_frame_seq #(.NUM_SYN(NUM_SYN), .CRC_W(CRC_W)) u_seq (
    .clk(clk), .rst(rst), .byte_req(byte_req),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .tx_byte(tx_byte),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din),
    .crc_q(crc_q), .done(done), .done_crc(done_crc)
  );
endmodule

// File: tb/bsc_frame_tx_tb.sv
module bsc_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        byte_req = 1'b0;
  logic [7:0]  tx_byte;
  logic        done;
  logic [15:0] done_crc;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0]  src_d[$];
  bit          src_l[$];
  int          src_g[$];
  int          gap_cnt = 0;
  logic [7:0]  cap[$];
  logic [15:0] dstat[$];
  int          dpos[$];
  logic [7:0]  pkt[$];
  logic [7:0]  exp_b[$];
  logic [15:0] exp_c[$];
  int          exp_e[$];

  always #2 clk = ~clk;

  bsc_frame_tx u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .byte_req(byte_req),
    .tx_byte(tx_byte), .done(done), .done_crc(done_crc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  // Queue pkt for the source; gap_pos: byte index preceded by one idle cycle
  task automatic queue_pkt(input int gap_pos);
    for (int i = 0; i < pkt.size(); i++) begin
      src_d.push_back(pkt[i]);
      src_l.push_back(i == pkt.size() - 1);
      src_g.push_back(i == gap_pos ? 1 : 0);
    end
  endtask

  // Expected line bytes per the requirements (R4, R5, R6, R7, R8)
  task automatic build_frame(input int gap_pos);
    logic [15:0] c;
    c = 16'h0000;
    exp_b.push_back(8'h16); exp_b.push_back(8'h16);
    exp_b.push_back(8'h10); exp_b.push_back(8'h02);
    for (int i = 0; i < pkt.size(); i++) begin
      if (i == gap_pos) begin exp_b.push_back(8'h10); exp_b.push_back(8'h16); end
      exp_b.push_back(pkt[i]);
      if (pkt[i] == 8'h10) exp_b.push_back(8'h10);
      c = ref_crc(c, pkt[i]);
    end
    c = ref_crc(c, 8'h03);
    exp_b.push_back(8'h10); exp_b.push_back(8'h03);
    exp_b.push_back(c[7:0]); exp_b.push_back(c[15:8]);
    exp_c.push_back(c);
    exp_e.push_back(exp_b.size() - 1);
  endtask

  task automatic clear_all();
    cap.delete(); dstat.delete(); dpos.delete();
    exp_b.delete(); exp_c.delete(); exp_e.delete();
  endtask

  task automatic cycle(input bit req);
    bit hs;
    @(negedge clk);
    if (gap_cnt == 0 && src_d.size() > 0) begin
      in_valid = 1'b1; in_data = src_d[0]; in_last = src_l[0];
    end else begin
      in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    end
    byte_req = req;
    #1 hs = in_valid && in_ready;
    @(posedge clk);
    #1;
    if (gap_cnt > 0) gap_cnt--;
    if (req) cap.push_back(tx_byte);
    if (done) begin dstat.push_back(done_crc); dpos.push_back(cap.size() - 1); end
    if (hs) begin
      void'(src_d.pop_front()); void'(src_l.pop_front()); void'(src_g.pop_front());
      if (src_g.size() > 0) gap_cnt = src_g[0];
    end
  endtask

  task automatic run(input int ndone, input int period, input int extra_req);
    int cyc = 0;
    int tail = 0;
    while (dstat.size() < ndone && cyc < 2000) begin
      cycle(cyc % period == 0);
      cyc++;
    end
    while (tail < extra_req) begin
      cycle(1'b1);
      tail++;
      exp_b.push_back(8'hFF);
    end
    byte_req = 1'b0;
  endtask

  task automatic compare_stream(input string req);
    int bad = -1;
    check(cap.size() == exp_b.size(), req, cap.size(), exp_b.size());
    for (int i = 0; i < exp_b.size() && i < cap.size(); i++)
      if (bad < 0 && cap[i] !== exp_b[i]) bad = i;
    if (bad >= 0) check(1'b0, req, cap[bad], exp_b[bad]);
    else check(1'b1, req, 0, 0);
  endtask

  task automatic compare_done();
    check(dstat.size() == exp_c.size(), "R10 count", dstat.size(), exp_c.size());
    for (int i = 0; i < exp_c.size() && i < dstat.size(); i++) begin
      check(dstat[i] == exp_c[i], "R10 done_crc", dstat[i], exp_c[i]);
      check(dpos[i] == exp_e[i], "R10 timing", dpos[i], exp_e[i]);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    byte_req = 1'b1; in_valid = 1'b1; in_data = 8'h55;
    #1;
    check(tx_byte == 8'hFF, "R1 tx_byte", tx_byte, 8'hFF);
    check(!done, "R1 done", done, 0);
    check(!in_ready, "R1 in_ready", in_ready, 0);
    byte_req = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_idle();
    clear_all();
    for (int i = 0; i < 5; i++) cycle(1'b1);
    cycle(1'b0); cycle(1'b0);
    for (int i = 0; i < 5; i++) exp_b.push_back(8'hFF);
    compare_stream("R2 idle fill");
    check(cap.size() == 5, "R3 one byte per strobe", cap.size(), 5);
  endtask

  task automatic t_plain();
    clear_all();
    pkt = '{8'h41, 8'h42, 8'h43, 8'h00};
    queue_pkt(-1); build_frame(-1);
    run(1, 1, 2);
    compare_stream("R4 R6 R7 plain frame");
    compare_done();
  endtask

  task automatic t_dle();
    clear_all();
    pkt = '{8'h10, 8'h55, 8'h10, 8'h10, 8'h7E, 8'h10};
    queue_pkt(-1); build_frame(-1);
    run(1, 3, 2);
    compare_stream("R5 R7 DLE doubling, slow strobe");
    compare_done();
  endtask

  task automatic t_b2b();
    clear_all();
    pkt = '{8'hA5, 8'h10};
    queue_pkt(-1); build_frame(-1);
    pkt = '{8'h01, 8'h02, 8'hFF};
    queue_pkt(-1); build_frame(-1);
    run(2, 1, 3);
    compare_stream("R11 back-to-back frames then R2 fill");
    compare_done();
  endtask

  task automatic t_gap();
    clear_all();
    pkt = '{8'h31, 8'h32, 8'h33, 8'h34};
    queue_pkt(2); build_frame(2);
    run(1, 1, 1);
    compare_stream("R8 pad pair on input gap");
    compare_done();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_plain();
    t_dle();
    t_b2b();
    t_gap();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule